// File: doc/BRIEF.md
# Four-Phase Pipelined Instruction Sequencer

This block sits at the front of a small single-word-instruction processor and sets its timing. It takes one input clock and divides it into four rotating, non-overlapping phase enables. Each set of four phases forms one instruction cycle. Over these phases it runs a two-stage overlap. While one instruction is being fetched from program memory, the previously fetched instruction sits in the instruction register and is executed.

The block owns the program counter and drives it as the program-memory address. It also owns the fetch latch, the instruction register and the data-memory operand-read and destination-write strobes. A taken branch, reported by the execute logic together with a target, redirects the program counter. It also discards the word that was being fetched in the same cycle, so a branch costs two instruction cycles. Decoding, the ALU and the memories sit outside the block.

Top module: `quad_phase_sequencer`

## Requirements
- R1: `phase_o` is one-hot: bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. It advances one phase per input clock in the order Q1, Q2, Q3, Q4 and back to Q1.
- R2: `prog_addr_o` changes only on the clock edge that starts Q1. With no branch taken it steps by one, modulo 2^PC_W.
- R3: The word on `prog_data_i` at the end of Q4 is captured into the fetch latch. It moves into `instr_o` at the end of Q1 of the next cycle and stays there through Q2 to Q4 of that cycle.
- R4: `dmem_rd_o` is high only in Q2 and `dmem_wr_o` only in Q4. Each is high there exactly when `instr_valid_o` is 1.
- R5: `branch_taken_i` and `branch_target_i` are sampled only at the end of Q4. A taken branch puts the target on `prog_addr_o` from the next Q1 onward. A taken branch driven in any other phase has no effect.
- R6: A taken branch discards the word fetched in its own cycle. In the next cycle `instr_valid_o` is 0 and neither strobe is raised. The target instruction executes two cycles after the branch.
- R7: A taken branch presented while `instr_valid_o` is 0 (a flushed or post-reset slot) is ignored.
- R8: `clkout_o` is high in Q1 and Q2 and low in Q3 and Q4.
- R9: Reset puts the block in Q1 with `prog_addr_o` at 0 and `instr_valid_o` at 0. The first instruction cycle is a no-operation, and the word at address 0 executes in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock, four per instruction cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_data_i | input | INSTR_W | Program-memory word at `prog_addr_o` |
| branch_taken_i | input | 1 | Executing instruction redirects the PC |
| branch_target_i | input | PC_W | Branch destination |
| phase_o | output | 4 | One-hot phase enables Q1..Q4 (bit 0 = Q1) |
| clkout_o | output | 1 | Quarter-rate clock, high in Q1 and Q2 |
| prog_addr_o | output | PC_W | Program counter / fetch address |
| instr_o | output | INSTR_W | Instruction register |
| instr_valid_o | output | 1 | Instruction register holds a real instruction |
| dmem_rd_o | output | 1 | Operand read strobe |
| dmem_wr_o | output | 1 | Destination write strobe |

## Verification
The phase outputs and `clkout_o` follow each edge at once. A fetch address is due in the Q1 after the edge that ends the previous Q4, and a fetched word shows in `instr_o` from Q2 of the following cycle. A branch shows up on the address in the very next Q1 and on `instr_valid_o` from Q2 of that cycle. The bench samples on falling edges and walks each instruction cycle phase by phase. It compares each phase with an instruction-level model that holds the fetch address and the executing slot, and it advances that model only once Q4 has ended. Branch inputs are raised in Q3 for real branches, and in Q1 and Q2 as decoys that must change nothing.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/phase_gen.sv
module phase_gen
  import seq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output phase_e                ph_o,
  output logic [NUM_PHASES-1:0] phase_o,
  output logic                  clkout_o
);
  phase_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_Q1;
    else         ph_q <= phase_e'(ph_q + 2'd1);
  end

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dec
    assign phase_o[g] = (ph_q == phase_e'(g));
  end

  assign clkout_o = (ph_q == PH_Q1) || (ph_q == PH_Q2);
  assign ph_o     = ph_q;
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int unsigned PC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,     // edge that starts Q1
  input  logic            load_i,    // resolved branch
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (adv_i)  pc_q <= load_i ? target_i : pc_q + 1'b1;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pipe_regs.sv
module pipe_regs #(
  parameter int unsigned INSTR_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,    // end of Q4
  input  logic               xfer_i,   // end of Q1
  input  logic               flush_i,
  input  logic [INSTR_W-1:0] data_i,
  output logic [INSTR_W-1:0] ir_o,
  output logic               ir_valid_o
);
  logic [INSTR_W-1:0] fl_q, ir_q;
  logic               fl_v_q, ir_v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_q   <= '0;
      fl_v_q <= 1'b0;
    end else if (cap_i) begin
      fl_q   <= data_i;
      fl_v_q <= !flush_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q   <= '0;
      ir_v_q <= 1'b0;
    end else if (xfer_i) begin
      ir_q   <= fl_q;
      ir_v_q <= fl_v_q;
    end
  end

  assign ir_o       = ir_q;
  assign ir_valid_o = ir_v_q;
endmodule

// File: rtl/quad_phase_sequencer.sv
module quad_phase_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned PC_W    = 8,
  parameter int unsigned INSTR_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] prog_data_i,
  input  logic               branch_taken_i,
  input  logic [PC_W-1:0]    branch_target_i,
  output logic [3:0]         phase_o,
  output logic               clkout_o,
  output logic [PC_W-1:0]    prog_addr_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic               instr_valid_o,
  output logic               dmem_rd_o,
  output logic               dmem_wr_o
);
  phase_e ph;
  logic   ir_v;
  logic   end_q4, end_q1, br_go;

  phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_o     (ph),
    .phase_o  (phase_o),
    .clkout_o (clkout_o)
  );

  assign end_q4 = (ph == PH_Q4);
  assign end_q1 = (ph == PH_Q1);
  // flushed slots cannot redirect
  assign br_go  = end_q4 && branch_taken_i && ir_v;

  pc_unit #(.PC_W(PC_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (end_q4),
    .load_i   (br_go),
    .target_i (branch_target_i),
    .pc_o     (prog_addr_o)
  );

  pipe_regs #(.INSTR_W(INSTR_W)) u_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (end_q4),
    .xfer_i     (end_q1),
    .flush_i    (br_go),
    .data_i     (prog_data_i),
    .ir_o       (instr_o),
    .ir_valid_o (ir_v)
  );

  assign instr_valid_o = ir_v;
  assign dmem_rd_o     = ir_v && (ph == PH_Q2);
  assign dmem_wr_o     = ir_v && (ph == PH_Q4);
endmodule

module quad_phase_sequencer_chk #(
  parameter int unsigned PC_W    = 8,
  parameter int unsigned INSTR_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               branch_taken_i,
  input logic [PC_W-1:0]    branch_target_i,
  input logic [3:0]         phase_o,
  input logic               clkout_o,
  input logic [PC_W-1:0]    prog_addr_o,
  input logic [INSTR_W-1:0] instr_o,
  input logic               instr_valid_o,
  input logic               dmem_rd_o,
  input logic               dmem_wr_o
);
  logic br_eff;
  assign br_eff = phase_o[3] && branch_taken_i && instr_valid_o;

  AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $countones(phase_o) == 1); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni) phase_o[3] |=> phase_o[0]); // R1
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni) phase_o[0] |=> phase_o[1]); // R1
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !phase_o[3] |=> $stable(prog_addr_o)); // R2
  AST_PC_INCR: assert property (@(posedge clk_i) disable iff (!rst_ni) (phase_o[3] && !br_eff) |=> prog_addr_o == PC_W'($past(prog_addr_o) + 1'b1)); // R2
  AST_IR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !phase_o[0] |=> $stable(instr_o)); // R3
  AST_RD_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni) dmem_rd_o |-> phase_o[1] && instr_valid_o); // R4
  AST_WR_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni) dmem_wr_o |-> phase_o[3] && instr_valid_o); // R4
  AST_BR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni) br_eff |=> prog_addr_o == $past(branch_target_i)); // R5
  AST_BR_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni) br_eff |=> ##1 !instr_valid_o); // R6
  AST_CLKOUT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(clkout_o) |-> phase_o[0]); // R8
  AST_CLKOUT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(clkout_o) |-> phase_o[2]); // R8
endmodule

bind quad_phase_sequencer quad_phase_sequencer_chk #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .branch_taken_i  (branch_taken_i),
  .branch_target_i (branch_target_i),
  .phase_o         (phase_o),
  .clkout_o        (clkout_o),
  .prog_addr_o     (prog_addr_o),
  .instr_o         (instr_o),
  .instr_valid_o   (instr_valid_o),
  .dmem_rd_o       (dmem_rd_o),
  .dmem_wr_o       (dmem_wr_o)
);

// File: tb/tb_quad_phase_sequencer.sv
module tb_quad_phase_sequencer;
  localparam int unsigned PC_W    = 8;
  localparam int unsigned INSTR_W = 14;
  localparam int unsigned NCYC    = 600;

  logic               clk_i = 1'b0;
  logic               rst_ni;
  logic [INSTR_W-1:0] prog_data_i;
  logic               branch_taken_i;
  logic [PC_W-1:0]    branch_target_i;
  logic [3:0]         phase_o;
  logic               clkout_o;
  logic [PC_W-1:0]    prog_addr_o;
  logic [INSTR_W-1:0] instr_o;
  logic               instr_valid_o;
  logic               dmem_rd_o;
  logic               dmem_wr_o;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  bit          done   = 1'b0;

  always #10 clk_i = ~clk_i;

  function automatic logic [INSTR_W-1:0] pm(input logic [PC_W-1:0] a);
    return {a[5:0] ^ 6'h2B, a};
  endfunction

  assign prog_data_i = pm(prog_addr_o);

  quad_phase_sequencer #(.PC_W(PC_W), .INSTR_W(INSTR_W)) dut (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .prog_data_i     (prog_data_i),
    .branch_taken_i  (branch_taken_i),
    .branch_target_i (branch_target_i),
    .phase_o         (phase_o),
    .clkout_o        (clkout_o),
    .prog_addr_o     (prog_addr_o),
    .instr_o         (instr_o),
    .instr_valid_o   (instr_valid_o),
    .dmem_rd_o       (dmem_rd_o),
    .dmem_wr_o       (dmem_wr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [PC_W-1:0] m_pc, m_eaddr;
    logic            m_ev;
    void'($urandom(32'd4242));
    rst_ni          = 1'b0;
    branch_taken_i  = 1'b0;
    branch_target_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 reset phase", 32'(phase_o), 32'h1);
    chk("R9 reset pc", 32'(prog_addr_o), 32'h0);
    chk("R9 reset valid", 32'(instr_valid_o), 32'h0);
    rst_ni = 1'b1;
    m_pc = '0; m_ev = 1'b0; m_eaddr = '0;

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      logic            br, spur, taken;
      logic [PC_W-1:0] tgt;
      br   = ($urandom % 4) == 0;
      tgt  = PC_W'($urandom);
      spur = ($urandom % 3) == 0;
      if (cyc == 0) br = 1'b1;                     // R7: post-reset slot
      if (cyc == 3) begin br = 1'b1; tgt = 8'h40; end
      if (cyc == 4) br = 1'b1;                     // R7: flushed slot
      if (cyc == 5) br = 1'b0;
      if (cyc == 6) begin br = 1'b1; tgt = 8'hFF; end
      if (cyc == 7 || cyc == 8) br = 1'b0;         // R2 wrap 255 -> 0

      // Q1
      chk("R1 phase Q1", 32'(phase_o), 32'h1);
      chk("R8 clkout Q1", 32'(clkout_o), 32'h1);
      chk("R2/R5 fetch addr", 32'(prog_addr_o), 32'(m_pc));
      chk("R4 no strobe Q1", 32'({dmem_rd_o, dmem_wr_o}), 32'h0);
      if (spur) begin  // R5: decoy branch outside Q4
        branch_taken_i  = 1'b1;
        branch_target_i = ~tgt;
      end
      @(negedge clk_i);
      // Q2
      chk("R1 phase Q2", 32'(phase_o), 32'h2);
      chk("R8 clkout Q2", 32'(clkout_o), 32'h1);
      chk("R6/R7/R9 exec valid", 32'(instr_valid_o), 32'(m_ev));
      if (m_ev) chk("R3 instr", 32'(instr_o), 32'(pm(m_eaddr)));
      chk("R4 rd Q2", 32'(dmem_rd_o), 32'(m_ev));
      chk("R4 no wr Q2", 32'(dmem_wr_o), 32'h0);
      chk("R5 pc unchanged by decoy", 32'(prog_addr_o), 32'(m_pc));
      @(negedge clk_i);
      // Q3
      chk("R1 phase Q3", 32'(phase_o), 32'h4);
      chk("R8 clkout Q3", 32'(clkout_o), 32'h0);
      chk("R4 no strobe Q3", 32'({dmem_rd_o, dmem_wr_o}), 32'h0);
      chk("R2 pc stable", 32'(prog_addr_o), 32'(m_pc));
      branch_taken_i  = br;
      branch_target_i = tgt;
      @(negedge clk_i);
      // Q4
      chk("R1 phase Q4", 32'(phase_o), 32'h8);
      chk("R8 clkout Q4", 32'(clkout_o), 32'h0);
      chk("R4 wr Q4", 32'(dmem_wr_o), 32'(m_ev));
      chk("R4 no rd Q4", 32'(dmem_rd_o), 32'h0);
      @(negedge clk_i);
      branch_taken_i = 1'b0;
      taken   = br && m_ev;
      m_eaddr = m_pc;
      m_ev    = !taken;
      m_pc    = taken ? tgt : PC_W'(m_pc + 1'b1);
    end
    summary();
  end
endmodule